// File: doc/BRIEF.md
# Wide-Word Horizontal Microsequencer

This block is the controller for a matrix-processing datapath. It holds a fixed microprogram of wide control words. Each word sets every control of the datapath in the same clock cycle, with no decode stage between the word and the outputs. One word carries these controls:
- the subcarrier plane, the read and write addresses and the per-element write enables of the matrix memory;
- the choice of stored matrix for each of the two operands;
- the routing modes of the crossbar into memory and of the crossbar out of memory;
- the function-unit result that is written back;
- one start bit and one enable bit for each of sixteen function units.

A pulse on `start` sets the program counter to address 0 and begins execution. Each word also names how the next address is formed. The sequencer can step to the following address, jump to an address field, or stop. When it stops, the `done` flag is set and every control output goes to zero, which is the no-operation state. The program image is a parameter fixed at elaboration, which is configuration time. A system fills it with its own program by overriding the parameter.

Top module: `uword_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge (synchronous, active high), the next state is `busy`=0, `done`=0 and `pc`=0, with every control output at zero.
- R2: A clock edge with `start` high (and `rst` low) sets `pc` to 0, `busy` to 1 and `done` to 0. This also applies while a program is already running, in which case the program restarts.
- R3: While `busy` is 1, every control output equals the matching field of the image word at address `pc` in the same cycle. The word is a packed struct `uword_t` whose fields run from MSB to LSB in this order: op[84:83], target[82:75], plane, rd_addr, wr_addr, wr_en, opa_sel, opb_sel, xin_mode, xout_mode, wb_sel, fu_start, fu_en[15:0].
- R4: While busy, a word with op 2'b00 makes `pc` advance by one at the next edge. The count wraps modulo 256.
- R5: While busy, a word with op 2'b01 loads `pc` with the word's target field at the next edge.
- R6: While busy, a word whose op has bit 1 set (2'b10 or 2'b11) is a halt. Its own fields still drive the outputs during its cycle. At the next edge `busy` falls, `done` rises and `pc` keeps the halt word's address.
- R7: While `busy` is 0, every control output is zero, whatever `pc` holds.
- R8: Once set, `done` stays at 1 until a start or a reset. `busy` and `done` are never 1 together.
- R9: The start and enable bits of the sixteen function units are independent. A single word can start and enable all sixteen units in the same cycle, with bit i driving unit i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin (or restart) execution at address 0 |
| busy | output | 1 | Program is executing |
| done | output | 1 | Program reached a halt word |
| pc | output | 8 | Current microprogram address |
| mem_plane | output | 3 | Subcarrier plane of the matrix memory |
| mem_rd_addr | output | 4 | Matrix memory read address |
| mem_wr_addr | output | 4 | Matrix memory write address |
| mem_wr_en | output | 16 | Per-element write enables |
| opa_sel | output | 2 | Stored matrix feeding operand A |
| opb_sel | output | 2 | Stored matrix feeding operand B |
| xin_mode | output | 4 | Routing mode of the crossbar into memory |
| xout_mode | output | 4 | Routing mode of the crossbar out of memory |
| wb_sel | output | 4 | Function-unit result written back to memory |
| fu_start | output | 16 | Start bit per function unit |
| fu_en | output | 16 | Enable bit per function unit |

## Verification
The bound checker watches the following on every cycle:
- the start response;
- increment and jump sequencing against the word actually being executed;
- the halt handshake between `busy` and `done`;
- that `done` is held;
- that the outputs stay at zero while idle.

The bench's scenarios are the only way to show three further behaviours. The first is that each output field comes from the right bit slice of the right word. The second is that all sixteen unit bits can be active together. The third is that the full address path through jumps, a halt at the top of the address space, a restart in mid-program and a reset in mid-program behaves as specified.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int ROM_DEPTH   = 256;
    localparam int PC_W        = $clog2(ROM_DEPTH);
    localparam int NUM_FU      = 16;
    localparam int FU_SEL_W    = $clog2(NUM_FU);
    localparam int NUM_MAT     = 4;
    localparam int MAT_SEL_W   = $clog2(NUM_MAT);
    localparam int MAT_ELEMS   = 16;
    localparam int NUM_PLANES  = 8;
    localparam int PLANE_W     = $clog2(NUM_PLANES);
    localparam int MEM_DEPTH   = 16;
    localparam int MADDR_W     = $clog2(MEM_DEPTH);
    localparam int XMODES      = 16;
    localparam int XMODE_W     = $clog2(XMODES);

    typedef enum logic [1:0] {
        OP_NEXT     = 2'b00,
        OP_JUMP     = 2'b01,
        OP_HALT     = 2'b10,
        OP_HALT_ALT = 2'b11
    } seq_op_e;

    typedef struct packed {
        seq_op_e                op;
        logic [PC_W-1:0]        target;
        logic [PLANE_W-1:0]     plane;
        logic [MADDR_W-1:0]     rd_addr;
        logic [MADDR_W-1:0]     wr_addr;
        logic [MAT_ELEMS-1:0]   wr_en;
        logic [MAT_SEL_W-1:0]   opa_sel;
        logic [MAT_SEL_W-1:0]   opb_sel;
        logic [XMODE_W-1:0]     xin_mode;
        logic [XMODE_W-1:0]     xout_mode;
        logic [FU_SEL_W-1:0]    wb_sel;
        logic [NUM_FU-1:0]      fu_start;
        logic [NUM_FU-1:0]      fu_en;
    } uword_t;

    localparam int UWORD_W = $bits(uword_t);

    typedef uword_t [ROM_DEPTH-1:0] image_t;

    function automatic logic is_halt(seq_op_e op);
        return op[1];
    endfunction

    // Small default microprogram: load operands, run two units, write back, stop.
    function automatic image_t default_image();
        image_t img;
        for (int a = 0; a < ROM_DEPTH; a++) begin
            img[a]    = '0;
            img[a].op = OP_HALT;
        end
        img[0].op       = OP_NEXT;
        img[0].opa_sel  = 2'd0;
        img[0].opb_sel  = 2'd1;
        img[0].xout_mode = 4'd1;
        img[0].fu_start = 16'h0003;
        img[0].fu_en    = 16'h0003;
        img[1].op       = OP_NEXT;
        img[1].fu_en    = 16'h0003;
        img[2].op       = OP_NEXT;
        img[2].wb_sel   = 4'd1;
        img[2].xin_mode = 4'd2;
        img[2].wr_en    = 16'hFFFF;
        img[2].wr_addr  = 4'd3;
        img[3].op       = OP_HALT;
        return img;
    endfunction

endpackage

// File: rtl/useq_rom.sv
module useq_rom
    import useq_pkg::*;
#(
    parameter image_t IMAGE = default_image()
) (
    input  logic [PC_W-1:0] addr,
    output uword_t          word
);
    assign word = IMAGE[addr];
endmodule

// File: rtl/useq_nextaddr.sv
module useq_nextaddr
    import useq_pkg::*;
(
    input  logic            start,
    input  logic            busy_q,
    input  logic            done_q,
    input  logic [PC_W-1:0] pc_q,
    input  seq_op_e         op,
    input  logic [PC_W-1:0] target,
    output logic [PC_W-1:0] pc_d,
    output logic            busy_d,
    output logic            done_d
);
    always_comb begin
        pc_d   = pc_q;
        busy_d = busy_q;
        done_d = done_q;
        if (start) begin
            pc_d   = '0;
            busy_d = 1'b1;
            done_d = 1'b0;
        end else if (busy_q) begin
            if (is_halt(op)) begin
                busy_d = 1'b0;
                done_d = 1'b1;
            end else if (op == OP_JUMP) begin
                pc_d = target;
            end else begin
                pc_d = pc_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/useq_fanout.sv
module useq_fanout
    import useq_pkg::*;
(
    input  uword_t                word,
    input  logic                  active,
    output logic [PLANE_W-1:0]    mem_plane,
    output logic [MADDR_W-1:0]    mem_rd_addr,
    output logic [MADDR_W-1:0]    mem_wr_addr,
    output logic [MAT_ELEMS-1:0]  mem_wr_en,
    output logic [MAT_SEL_W-1:0]  opa_sel,
    output logic [MAT_SEL_W-1:0]  opb_sel,
    output logic [XMODE_W-1:0]    xin_mode,
    output logic [XMODE_W-1:0]    xout_mode,
    output logic [FU_SEL_W-1:0]   wb_sel,
    output logic [NUM_FU-1:0]     fu_start,
    output logic [NUM_FU-1:0]     fu_en
);
    uword_t gated;

    assign gated = active ? word : '0;

    assign mem_plane   = gated.plane;
    assign mem_rd_addr = gated.rd_addr;
    assign mem_wr_addr = gated.wr_addr;
    assign mem_wr_en   = gated.wr_en;
    assign opa_sel     = gated.opa_sel;
    assign opb_sel     = gated.opb_sel;
    assign xin_mode    = gated.xin_mode;
    assign xout_mode   = gated.xout_mode;
    assign wb_sel      = gated.wb_sel;

    for (genvar u = 0; u < NUM_FU; u++) begin : g_unit
        assign fu_start[u] = gated.fu_start[u];
        assign fu_en[u]    = gated.fu_en[u];
    end
endmodule

// File: rtl/uword_sequencer.sv
module uword_sequencer
    import useq_pkg::*;
#(
    parameter image_t IMAGE = default_image()
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    output logic                  busy,
    output logic                  done,
    output logic [PC_W-1:0]       pc,
    output logic [PLANE_W-1:0]    mem_plane,
    output logic [MADDR_W-1:0]    mem_rd_addr,
    output logic [MADDR_W-1:0]    mem_wr_addr,
    output logic [MAT_ELEMS-1:0]  mem_wr_en,
    output logic [MAT_SEL_W-1:0]  opa_sel,
    output logic [MAT_SEL_W-1:0]  opb_sel,
    output logic [XMODE_W-1:0]    xin_mode,
    output logic [XMODE_W-1:0]    xout_mode,
    output logic [FU_SEL_W-1:0]   wb_sel,
    output logic [NUM_FU-1:0]     fu_start,
    output logic [NUM_FU-1:0]     fu_en
);
    logic [PC_W-1:0] pc_q, pc_d;
    logic            busy_q, busy_d;
    logic            done_q, done_d;
    uword_t          cur_word;

    useq_rom #(.IMAGE(IMAGE)) u_rom (
        .addr (pc_q),
        .word (cur_word)
    );

    useq_nextaddr u_next (
        .start  (start),
        .busy_q (busy_q),
        .done_q (done_q),
        .pc_q   (pc_q),
        .op     (cur_word.op),
        .target (cur_word.target),
        .pc_d   (pc_d),
        .busy_d (busy_d),
        .done_d (done_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            pc_q   <= pc_d;
            busy_q <= busy_d;
            done_q <= done_d;
        end
    end

    useq_fanout u_fan (
        .word        (cur_word),
        .active      (busy_q),
        .mem_plane   (mem_plane),
        .mem_rd_addr (mem_rd_addr),
        .mem_wr_addr (mem_wr_addr),
        .mem_wr_en   (mem_wr_en),
        .opa_sel     (opa_sel),
        .opb_sel     (opb_sel),
        .xin_mode    (xin_mode),
        .xout_mode   (xout_mode),
        .wb_sel      (wb_sel),
        .fu_start    (fu_start),
        .fu_en       (fu_en)
    );

    assign pc   = pc_q;
    assign busy = busy_q;
    assign done = done_q;
endmodule

// File: rtl/useq_checker.sv
module useq_checker
    import useq_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  start,
    input logic                  busy,
    input logic                  done,
    input logic [PC_W-1:0]       pc,
    input uword_t                cur_word,
    input logic [PLANE_W-1:0]    mem_plane,
    input logic [MADDR_W-1:0]    mem_rd_addr,
    input logic [MADDR_W-1:0]    mem_wr_addr,
    input logic [MAT_ELEMS-1:0]  mem_wr_en,
    input logic [MAT_SEL_W-1:0]  opa_sel,
    input logic [MAT_SEL_W-1:0]  opb_sel,
    input logic [XMODE_W-1:0]    xin_mode,
    input logic [XMODE_W-1:0]    xout_mode,
    input logic [FU_SEL_W-1:0]   wb_sel,
    input logic [NUM_FU-1:0]     fu_start,
    input logic [NUM_FU-1:0]     fu_en
);
    logic any_ctrl;
    assign any_ctrl = (|mem_plane) | (|mem_rd_addr) | (|mem_wr_addr) | (|mem_wr_en)
                    | (|opa_sel) | (|opb_sel) | (|xin_mode) | (|xout_mode)
                    | (|wb_sel) | (|fu_start) | (|fu_en);

    // R2
    a_r2_start_enters_run: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy && !done && pc == '0));

    // R4
    a_r4_step: assert property (@(posedge clk) disable iff (rst)
        (busy && !start && cur_word.op == OP_NEXT) |=> (busy && pc == $past(pc) + 1'b1));

    // R5
    a_r5_jump: assert property (@(posedge clk) disable iff (rst)
        (busy && !start && cur_word.op == OP_JUMP) |=> (busy && pc == $past(cur_word.target)));

    // R6
    a_r6_halt_stops: assert property (@(posedge clk) disable iff (rst)
        (busy && !start && cur_word.op[1]) |=> (!busy && done && $stable(pc)));

    // R7
    a_r7_idle_nop: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !any_ctrl);

    // R8
    a_r8_done_hold: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    // R8
    a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));
endmodule

bind uword_sequencer useq_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .pc          (pc),
    .cur_word    (cur_word),
    .mem_plane   (mem_plane),
    .mem_rd_addr (mem_rd_addr),
    .mem_wr_addr (mem_wr_addr),
    .mem_wr_en   (mem_wr_en),
    .opa_sel     (opa_sel),
    .opb_sel     (opb_sel),
    .xin_mode    (xin_mode),
    .xout_mode   (xout_mode),
    .wb_sel      (wb_sel),
    .fu_start    (fu_start),
    .fu_en       (fu_en)
);

// File: tb/uword_sequencer_test.sv
`timescale 1ns/1ps
module uword_sequencer_test;
    import useq_pkg::*;

    // Bench microprogram: fields derived from the address so every word is distinct.
    function automatic image_t tb_image();
        image_t img;
        for (int a = 0; a < ROM_DEPTH; a++) begin
            logic [7:0] av;
            av = 8'(a);
            img[a]           = '0;
            img[a].op        = OP_NEXT;
            img[a].plane     = av[2:0];
            img[a].rd_addr   = av[3:0];
            img[a].wr_addr   = ~av[3:0];
            img[a].wr_en     = 16'h1 << av[3:0];
            img[a].opa_sel   = av[1:0];
            img[a].opb_sel   = ~av[1:0];
            img[a].xin_mode  = av[3:0];
            img[a].xout_mode = av[7:4];
            img[a].wb_sel    = av[3:0] ^ 4'h5;
            img[a].fu_start  = 16'h1 << av[3:0];
            img[a].fu_en     = ~(16'h1 << av[3:0]);
        end
        img[3].op        = OP_JUMP;
        img[3].target    = 8'd10;
        img[11].fu_start = 16'hFFFF;
        img[11].fu_en    = 16'hFFFF;
        img[12].op       = OP_JUMP;
        img[12].target   = 8'd253;
        img[255].op      = OP_HALT_ALT;
        return img;
    endfunction

    localparam image_t TB_IMAGE = tb_image();
    localparam int SEQ_LEN = 10;
    localparam int SEQ [SEQ_LEN] = '{0, 1, 2, 3, 10, 11, 12, 253, 254, 255};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic                 busy, done;
    logic [PC_W-1:0]      pc;
    logic [PLANE_W-1:0]   mem_plane;
    logic [MADDR_W-1:0]   mem_rd_addr, mem_wr_addr;
    logic [MAT_ELEMS-1:0] mem_wr_en;
    logic [MAT_SEL_W-1:0] opa_sel, opb_sel;
    logic [XMODE_W-1:0]   xin_mode, xout_mode;
    logic [FU_SEL_W-1:0]  wb_sel;
    logic [NUM_FU-1:0]    fu_start, fu_en;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    uword_sequencer #(.IMAGE(TB_IMAGE)) uut (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .pc(pc),
        .mem_plane(mem_plane), .mem_rd_addr(mem_rd_addr), .mem_wr_addr(mem_wr_addr),
        .mem_wr_en(mem_wr_en), .opa_sel(opa_sel), .opb_sel(opb_sel),
        .xin_mode(xin_mode), .xout_mode(xout_mode), .wb_sel(wb_sel),
        .fu_start(fu_start), .fu_en(fu_en)
    );

    function automatic uword_t observed();
        uword_t w;
        w           = '0;
        w.plane     = mem_plane;
        w.rd_addr   = mem_rd_addr;
        w.wr_addr   = mem_wr_addr;
        w.wr_en     = mem_wr_en;
        w.opa_sel   = opa_sel;
        w.opb_sel   = opb_sel;
        w.xin_mode  = xin_mode;
        w.xout_mode = xout_mode;
        w.wb_sel    = wb_sel;
        w.fu_start  = fu_start;
        w.fu_en     = fu_en;
        return w;
    endfunction

    function automatic uword_t expected_ctrl(int a);
        uword_t w;
        w        = TB_IMAGE[a];
        w.op     = OP_NEXT;
        w.target = '0;
        return w;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_state(input string tag, input bit eb, input bit ed, input int epc);
        check(busy == eb, {tag, " busy"}, 128'(busy), 128'(eb));
        check(done == ed, {tag, " done"}, 128'(done), 128'(ed));
        check(pc == 8'(epc), {tag, " pc"}, 128'(pc), 128'(epc));
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R6 watchdog actual=running expected=halted");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check_state("R1 reset", 1'b0, 1'b0, 0);
        check(observed() == '0, "R1 outputs zero", 128'(observed()), 128'h0);

        // Walk the expected address sequence (R2, R3, R4, R5, R9)
        pulse_start();
        for (int i = 0; i < SEQ_LEN; i++) begin
            check_state("R2 R4 R5 sequence", 1'b1, 1'b0, SEQ[i]);
            check(observed() == expected_ctrl(SEQ[i]), "R3 fields match word",
                  128'(observed()), 128'(expected_ctrl(SEQ[i])));
            if (SEQ[i] == 11)
                check(fu_start == 16'hFFFF && fu_en == 16'hFFFF, "R9 all units",
                      128'({fu_start, fu_en}), 128'hFFFFFFFF);
            @(negedge clk);
        end

        // R6: halt lands; R7 idle zero; R8 done held
        check_state("R6 halted", 1'b0, 1'b1, 255);
        for (int k = 0; k < 4; k++) begin
            check(observed() == '0, "R7 idle nop", 128'(observed()), 128'h0);
            check(done == 1'b1 && busy == 1'b0, "R8 done held", 128'({busy, done}), 128'h1);
            @(negedge clk);
        end

        // R2: restart clears done, then restart mid-run
        pulse_start();
        check_state("R2 restart", 1'b1, 1'b0, 0);
        @(negedge clk);
        @(negedge clk);
        check_state("R4 step", 1'b1, 1'b0, 2);
        pulse_start();
        check_state("R2 restart mid-run", 1'b1, 1'b0, 0);
        check(observed() == expected_ctrl(0), "R3 word 0", 128'(observed()),
              128'(expected_ctrl(0)));

        // R1: reset in mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_state("R1 reset mid-run", 1'b0, 1'b0, 0);
        check(observed() == '0, "R1 R7 outputs zero", 128'(observed()), 128'h0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule